// File: doc/BRIEF.md
# Framed Link Message Responder

This block answers a host that talks to it through four byte-wide link registers. The host writes an outbound byte stream into the transmit data register. The block splits that stream into frames. Each frame has a length word, then an optional action code, then payload bytes. The block swallows every payload byte, so it always knows where the next frame begins, and it never needs to understand the payload.

When a renderer request ends, the block stores a reply frame that echoes the request's action code. The host then reads the reply one byte at a time from the receive data register. Download frames are absorbed and get no reply. Before any reply, and straight after reset, the block offers a fixed set of canned host-server request frames. This lets the host finish its startup exchange without any real peer.

Top module: `link_msg_responder`

## Requirements
- R1: The register select `reg_sel` decodes as follows.
  - 0 is receive data: a read returns the waiting byte.
  - 1 is transmit data: a write feeds one byte to the parser, and a read returns 0.
  - 2 is receive status: bit 0 is 1 while any byte is waiting, and bits 7..1 are 0.
  - 3 is transmit status: it always reads 8'h01.
- R2: After reset, receive data yields NUM_BOOT_REQ identical host-server request frames, one after another. Each frame is the bytes 01 00 00 80 then BOOT_TAG (default 42 = 8'h2A): a length word of 32'h8000_0001 followed by a one-byte tag.
- R3: A read of receive data while no byte is waiting returns 0 and changes nothing.
- R4: Each frame starts with a 4-byte length word, sent least significant byte first. Bits 15..0 give the number of bytes that follow the word. When bit 31 is 1, the frame is host-server routed: all its bytes are absorbed and no reply is produced.
- R5: A renderer frame has bit 31 = 0 and a count of at least 4. Its first 4 following bytes form the action code, least significant byte first. When the final byte of the frame is accepted, a reply becomes readable from the next cycle. The reply is the 8 bytes 04 00 00 00 a0 a1 a2 a3, where a0 is the action's low byte.
- R6: Renderer frames whose action code is 18, 19, 20 or 21 are absorbed without a reply. Action codes 17 and 22 are answered.
- R7: A length word with count 0 closes the frame at once. The next byte starts a new length word, and no reply is produced.
- R8: A renderer frame with a count of 1 to 3 is absorbed without a reply.
- R9: The reply store holds one frame. A new reply-producing request overwrites the pending reply, even one that has been partly read. Reading then restarts at byte 0 of the new reply.
- R10: Writes to selects 0, 2 and 3 have no effect on the parser.
- R11: Pending startup requests are read out before any reply that was stored while they were pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Link register select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of select 0 consumes the byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |

## Verification
The bench builds the block with its default parameters: three startup requests with tag 42, and a download action range of 18 to 21. With these values the startup sequence is short enough to read out in full. Both ends of the download range, and the codes just outside it, can be sent directly. Frames of 0 to 3 bytes and one 40-byte routed frame test the remaining-byte counter at both ends. A request sent before the startup requests are read, and a second request arriving in the middle of a reply, check the ordering and overwrite rules.

// File: rtl/link_resp_pkg.sv
package link_resp_pkg;

   localparam logic [1:0] REG_RX_DATA = 2'd0;
   localparam logic [1:0] REG_TX_DATA = 2'd1;
   localparam logic [1:0] REG_RX_STAT = 2'd2;
   localparam logic [1:0] REG_TX_STAT = 2'd3;

   localparam int LEN_W = 16;
   localparam logic [31:0] ROUTE_FLAG = 32'h8000_0000;
   localparam logic [31:0] REPLY_LEN_WORD = 32'd4;

   typedef enum logic [1:0] {
      PS_HDR  = 2'd0,
      PS_ACT  = 2'd1,
      PS_BODY = 2'd2
   } parse_st_t;

endpackage

// File: rtl/link_frame_parser.sv
module link_frame_parser
   import link_resp_pkg::*;
#(
   parameter int DL_FIRST = 18,
   parameter int DL_LAST  = 21
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        byte_vld,
   input  logic [7:0]  byte_in,
   output logic        req_vld,
   output logic [31:0] req_action,
   output parse_st_t   pst
);

   localparam logic [31:0] DL_LO = DL_FIRST[31:0];
   localparam logic [31:0] DL_HI = DL_LAST[31:0];

   parse_st_t        st;
   logic [1:0]       hdr_idx;
   logic [LEN_W-1:0] len_lo;
   logic [LEN_W-1:0] rem;
   logic             routed;
   logic [1:0]       act_idx;
   logic [31:0]      act_sr;
   logic [31:0]      act_now;
   logic             frame_last;

   function automatic logic is_dl(input logic [31:0] a);
      return (a >= DL_LO) && (a <= DL_HI);
   endfunction

   assign pst = st;

   always_comb begin
      act_now    = {byte_in, act_sr[31:8]};
      frame_last = byte_vld && (st != PS_HDR) && (rem == LEN_W'(1));
      req_vld    = 1'b0;
      req_action = act_sr;
      if (frame_last && !routed) begin
         if (st == PS_ACT) begin
            req_action = act_now;
            req_vld    = (act_idx == 2'd3) && !is_dl(act_now);
         end else begin
            req_vld    = !is_dl(act_sr);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= PS_HDR;
         hdr_idx <= 2'd0;
         len_lo  <= '0;
         rem     <= '0;
         routed  <= 1'b0;
         act_idx <= 2'd0;
         act_sr  <= '0;
      end else if (byte_vld) begin
         case (st)
            PS_HDR: begin
               hdr_idx <= hdr_idx + 2'd1;
               case (hdr_idx)
                  2'd0: len_lo[7:0]  <= byte_in;
                  2'd1: len_lo[15:8] <= byte_in;
                  2'd3: begin
                     if (len_lo != '0) begin
                        rem     <= len_lo;
                        routed  <= byte_in[7];
                        act_idx <= 2'd0;
                        st      <= byte_in[7] ? PS_BODY : PS_ACT;
                     end
                  end
                  default: ;
               endcase
            end
            PS_ACT: begin
               act_sr  <= act_now;
               act_idx <= act_idx + 2'd1;
               rem     <= rem - LEN_W'(1);
               if (rem == LEN_W'(1))
                  st <= PS_HDR;
               else if (act_idx == 2'd3)
                  st <= PS_BODY;
            end
            PS_BODY: begin
               rem <= rem - LEN_W'(1);
               if (rem == LEN_W'(1))
                  st <= PS_HDR;
            end
            default: st <= PS_HDR;
         endcase
      end
   end

   // R4: inside a frame the remaining count never sits at zero
   assert_rem_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st != PS_HDR) |-> (rem != '0));

endmodule

// File: rtl/link_reply_source.sv
module link_reply_source
   import link_resp_pkg::*;
#(
   parameter int         NUM_BOOT_REQ = 3,
   parameter logic [7:0] BOOT_TAG     = 8'd42
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic [31:0] load_action,
   input  logic        pop,
   output logic        avail,
   output logic [7:0]  byte_out
);

   localparam logic [31:0] BOOT_LEN = ROUTE_FLAG | 32'd1;

   logic        boot_active;
   logic [7:0]  boot_byte;
   logic        rep_vld;
   logic [2:0]  rep_pos;
   logic [31:0] rep_act;
   logic [63:0] rep_frame;
   logic [7:0]  rep_byte;

   generate
      if (NUM_BOOT_REQ > 0) begin : g_boot
         localparam int BFW = $clog2(NUM_BOOT_REQ + 1);
         logic [BFW-1:0] frm;
         logic [2:0]     bpos;

         assign boot_active = (frm != BFW'(NUM_BOOT_REQ));

         always_comb begin
            case (bpos)
               3'd0:    boot_byte = BOOT_LEN[7:0];
               3'd1:    boot_byte = BOOT_LEN[15:8];
               3'd2:    boot_byte = BOOT_LEN[23:16];
               3'd3:    boot_byte = BOOT_LEN[31:24];
               default: boot_byte = BOOT_TAG;
            endcase
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               frm  <= '0;
               bpos <= 3'd0;
            end else if (pop && boot_active) begin
               if (bpos == 3'd4) begin
                  bpos <= 3'd0;
                  frm  <= frm + BFW'(1);
               end else begin
                  bpos <= bpos + 3'd1;
               end
            end
         end
      end else begin : g_noboot
         assign boot_active = 1'b0;
         assign boot_byte   = 8'h00;
      end
   endgenerate

   assign rep_frame = {rep_act, REPLY_LEN_WORD};
   assign rep_byte  = rep_frame[{rep_pos, 3'b000} +: 8];
   assign avail     = boot_active || rep_vld;
   assign byte_out  = boot_active ? boot_byte : (rep_vld ? rep_byte : 8'h00);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rep_vld <= 1'b0;
         rep_pos <= 3'd0;
         rep_act <= '0;
      end else if (load) begin
         rep_vld <= 1'b1;
         rep_pos <= 3'd0;
         rep_act <= load_action;
      end else if (pop && !boot_active && rep_vld) begin
         rep_pos <= rep_pos + 3'd1;
         if (rep_pos == 3'd7)
            rep_vld <= 1'b0;
      end
   end

   // R11: while startup requests remain, the reply read position is untouched
   assert_boot_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_active && !load) |=> ($stable(rep_pos) && $stable(rep_vld)));

   // R3: popping an empty source leaves it empty
   assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !avail && !load) |=> !avail);

endmodule

// File: rtl/link_msg_responder.sv
module link_msg_responder
   import link_resp_pkg::*;
#(
   parameter int         NUM_BOOT_REQ = 3,
   parameter logic [7:0] BOOT_TAG     = 8'd42,
   parameter int         DL_FIRST     = 18,
   parameter int         DL_LAST      = 21
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] reg_sel,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [7:0] wdata,
   output logic [7:0] rdata
);

   initial begin
      assert (NUM_BOOT_REQ >= 0 && NUM_BOOT_REQ <= 255)
         else $error("NUM_BOOT_REQ out of range");
      assert (DL_FIRST >= 0 && DL_FIRST <= DL_LAST)
         else $error("download action range is empty or negative");
   end

   logic        byte_vld;
   logic        pop;
   logic        req_vld;
   logic [31:0] req_action;
   parse_st_t   pst;
   logic        avail;
   logic [7:0]  src_byte;

   assign byte_vld = wr_en && (reg_sel == REG_TX_DATA);
   assign pop      = rd_en && (reg_sel == REG_RX_DATA);

   link_frame_parser #(
      .DL_FIRST (DL_FIRST),
      .DL_LAST  (DL_LAST)
   ) u_parser (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_vld   (byte_vld),
      .byte_in    (wdata),
      .req_vld    (req_vld),
      .req_action (req_action),
      .pst        (pst)
   );

   link_reply_source #(
      .NUM_BOOT_REQ (NUM_BOOT_REQ),
      .BOOT_TAG     (BOOT_TAG)
   ) u_source (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (req_vld),
      .load_action (req_action),
      .pop         (pop),
      .avail       (avail),
      .byte_out    (src_byte)
   );

   always_comb begin
      case (reg_sel)
         REG_RX_DATA: rdata = src_byte;
         REG_RX_STAT: rdata = {7'b0, avail};
         REG_TX_STAT: rdata = 8'h01;
         default:     rdata = 8'h00;
      endcase
   end

   // R5: a completed request is readable on the next cycle
   assert_reply_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> avail);

   // R6: no reply is ever queued for a download action
   assert_no_dl_reply_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |-> !((req_action >= DL_FIRST[31:0]) && (req_action <= DL_LAST[31:0])));

   // R10: the parser only moves on transmit-data writes
   assert_ignore_other_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |=> $stable(pst));

endmodule

// File: tb/tb_link_msg_responder.sv
`timescale 1ns/1ps
module tb_link_msg_responder;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] reg_sel;
   logic       wr_en;
   logic       rd_en;
   logic [7:0] wdata;
   logic [7:0] rdata;

   always #2.5 clk = ~clk;

   link_msg_responder dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .reg_sel (reg_sel),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .wdata   (wdata),
      .rdata   (rdata)
   );

   int    n_cmp  = 0;
   int    n_fail = 0;
   bit    done   = 0;
   string phase  = "R1";

   // behavioural reference
   logic [7:0] boot_q[$];
   logic [7:0] rep_q[$];
   int         hpos, lenlo, rem, acnt;
   bit         in_frame, routed;
   logic [31:0] act;

   function automatic logic [7:0] expect_rd(input logic [1:0] s);
      case (s)
         2'd0: return boot_q.size() > 0 ? boot_q[0] : (rep_q.size() > 0 ? rep_q[0] : 8'h00);
         2'd2: return (boot_q.size() > 0 || rep_q.size() > 0) ? 8'h01 : 8'h00;
         2'd3: return 8'h01;
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_reset();
      boot_q.delete();
      rep_q.delete();
      for (int i = 0; i < 3; i++) begin
         boot_q.push_back(8'h01); boot_q.push_back(8'h00);
         boot_q.push_back(8'h00); boot_q.push_back(8'h80);
         boot_q.push_back(8'h2A);
      end
      hpos = 0; lenlo = 0; rem = 0; acnt = 0; in_frame = 0; routed = 0; act = 0;
   endtask

   task automatic model_write(input logic [7:0] b);
      if (!in_frame) begin
         if (hpos == 0) lenlo = b;
         if (hpos == 1) lenlo = lenlo + (b * 256);
         if (hpos == 3 && lenlo != 0) begin
            in_frame = 1; rem = lenlo; routed = b[7]; acnt = 0; act = 0;
         end
         hpos = (hpos + 1) % 4;
      end else begin
         if (!routed && acnt < 4) begin
            act = act | (32'(b) << (8 * acnt));
            acnt++;
         end
         rem--;
         if (rem == 0) begin
            in_frame = 0;
            if (!routed && acnt == 4 && !(act >= 18 && act <= 21)) begin
               rep_q.delete();
               rep_q.push_back(8'h04); rep_q.push_back(8'h00);
               rep_q.push_back(8'h00); rep_q.push_back(8'h00);
               for (int k = 0; k < 4; k++) rep_q.push_back(act[8*k +: 8]);
            end
         end
      end
   endtask

   task automatic model_pop();
      if (boot_q.size() > 0) void'(boot_q.pop_front());
      else if (rep_q.size() > 0) void'(rep_q.pop_front());
   endtask

   task automatic report(input string tag, input logic [7:0] a, input logic [7:0] e);
      n_cmp++;
      if (a !== e) begin
         n_fail++;
         $display("FAIL %s at %0t: actual=%02h expected=%02h", tag, $time, a, e);
      end
   endtask

   // every-clock comparison against the reference
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done)
         report({phase, " sel=", $sformatf("%0d", reg_sel)}, rdata, expect_rd(reg_sel));
   end

   task automatic wr(input logic [1:0] s, input logic [7:0] b);
      reg_sel = s; wdata = b; wr_en = 1'b1;
      @(posedge clk); #1;
      if (s == 2'd1) model_write(b);
      wr_en = 1'b0; reg_sel = 2'd2;
   endtask

   task automatic rd(input logic [1:0] s);
      reg_sel = s; rd_en = 1'b1;
      @(posedge clk); #1;
      if (s == 2'd0) model_pop();
      rd_en = 1'b0; reg_sel = 2'd2;
   endtask

   task automatic send_word(input logic [31:0] w);
      for (int k = 0; k < 4; k++) wr(2'd1, w[8*k +: 8]);
   endtask

   task automatic send_req(input logic [31:0] a, input int extra);
      send_word(32'(4 + extra));
      send_word(a);
      for (int k = 0; k < extra; k++) wr(2'd1, 8'(k * 37 + 5));
   endtask

   task automatic read_n(input int n);
      for (int k = 0; k < n; k++) rd(2'd0);
   endtask

   task automatic chk_stat(input string tag, input logic [7:0] e);
      reg_sel = 2'd2; #0.5;
      report(tag, rdata, e);
   endtask

   task automatic chk_rx(input string tag, input logic [7:0] e);
      reg_sel = 2'd0; #0.5;
      report(tag, rdata, e);
      reg_sel = 2'd2;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_fail++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; reg_sel = 2'd2; wr_en = 1'b0; rd_en = 1'b0; wdata = 8'h00;
      model_reset();
      repeat (3) @(posedge clk); #1;
      chk_stat("R2 reset status", 8'h01);
      rst_n = 1'b1;
      @(posedge clk); #1;

      phase = "R1";
      rd(2'd3); rd(2'd1);
      chk_rx("R2 first boot byte", 8'h01);

      phase = "R11";
      send_req(32'h0A0B0C0D, 1);
      chk_rx("R11 boot still first", 8'h01);
      read_n(15);
      chk_rx("R11 reply after boot", 8'h04);
      read_n(8);
      chk_stat("R2 drained", 8'h00);

      phase = "R3";
      rd(2'd0); rd(2'd0);
      chk_stat("R3 empty read", 8'h00);
      chk_rx("R3 empty data", 8'h00);

      phase = "R4";
      send_word(32'h8000_0028);
      for (int k = 0; k < 40; k++) wr(2'd1, (k % 2) ? 8'hFF : 8'h00);
      chk_stat("R4 routed no reply", 8'h00);
      send_req(32'h1122_3344, 2);
      chk_stat("R5 reply ready", 8'h01);
      read_n(4);
      chk_rx("R5 action low byte", 8'h44);
      read_n(4);

      phase = "R6";
      for (int a = 18; a <= 21; a++) send_req(32'(a), 3);
      chk_stat("R6 download silent", 8'h00);
      send_req(32'd17, 0);
      chk_stat("R6 action 17 answered", 8'h01);
      read_n(8);
      send_req(32'd22, 1);
      chk_stat("R6 action 22 answered", 8'h01);
      read_n(8);

      phase = "R7";
      send_word(32'h0000_0000);
      chk_stat("R7 zero length silent", 8'h00);
      send_req(32'h0000_0055, 0);
      read_n(4);
      chk_rx("R7 aligned action", 8'h55);
      read_n(4);

      phase = "R8";
      send_word(32'd2); wr(2'd1, 8'h12); wr(2'd1, 8'h34);
      chk_stat("R8 two-byte silent", 8'h00);
      send_word(32'd3); wr(2'd1, 8'h01); wr(2'd1, 8'h02); wr(2'd1, 8'h03);
      chk_stat("R8 three-byte silent", 8'h00);
      send_req(32'h0000_0066, 0);
      read_n(8);

      phase = "R9";
      send_req(32'hAAAA_0001, 2);
      read_n(3);
      send_req(32'hBBBB_0002, 0);
      chk_rx("R9 restart at byte 0", 8'h04);
      read_n(4);
      chk_rx("R9 new action", 8'h02);
      read_n(4);
      chk_stat("R9 drained", 8'h00);

      phase = "R10";
      send_word(32'd4);
      wr(2'd0, 8'hDE); wr(2'd2, 8'hAD); wr(2'd3, 8'hBE);
      send_word(32'h0000_0077);
      chk_stat("R10 other writes ignored", 8'h01);
      read_n(4);
      chk_rx("R10 action intact", 8'h77);
      read_n(4);

      repeat (2) @(posedge clk); #1;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

endmodule